// File: doc/BRIEF.md
# ASCII Hex Command Frame Parser

This block turns a stream of typed text characters into register bus requests. It takes one byte on each cycle where the input strobe is high, normally straight from a serial receiver. A command is a single leading letter followed by hexadecimal digits and ends at a line break. When a command is well formed, the block emits a one-cycle request that carries a 16-bit address, 16-bit data and a direction flag. It executes nothing itself.

A read command is the letter `R` followed by four address digits. A write command is the letter `W` followed by eight digits: the address, then the data. Digits are taken most significant nibble first. A frame ends at carriage return (0x0D) or line feed (0x0A). A bare line break while idle is ignored, so the pair CR then LF counts as a single end of line. A frame with the wrong number of digits, a character that is not hex, or an unknown leading letter is dropped without any output. In every case the parser is back in idle after the terminator.

Top module: `hex_cmd_parser`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `req_valid` is 0. After reset the parser is idle, so a frame that was cut off by reset does not continue: a byte that is not a command letter is treated as a bad lead.
- R2: `W` (0x57) followed by exactly 8 hex digits and a terminator gives one request with `req_rw`=1. `req_addr` is the first four digits and `req_data` is the last four, most significant nibble first.
- R3: `R` (0x52) followed by exactly 4 hex digits and a terminator gives one request with `req_rw`=0, `req_addr` set to the digits, and `req_data`=0.
- R4: Either CR (0x0D) or LF (0x0A) ends a frame. A terminator that arrives while idle, including the LF of a CR LF pair or an empty line, gives no request and no error.
- R5: `req_valid` is high for exactly one cycle: the cycle right after the clock edge that accepts the terminator byte.
- R6: A command letter followed by too few or too many digits (for example 0, 3 or 5 for `R`, or 7 or 9 for `W`) gives no request.
- R7: A character other than 0-9, A-F or a-f in a digit position gives no request for that frame.
- R8: The lowercase digits a-f decode to the same values as A-F.
- R9: A first byte other than `R`, `W`, CR or LF makes the parser discard bytes up to the next terminator. The parser then returns to idle, and the next frame decodes normally.
- R10: Bytes are taken only in cycles where `in_valid` is high. The value on `in_data` in other cycles, terminators included, has no effect.
- R11: Frames sent back to back, with no idle cycle between them, each decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe for `in_data` |
| in_data | input | 8 | Incoming ASCII byte |
| req_valid | output | 1 | One-cycle request pulse |
| req_addr | output | 16 | Request address |
| req_data | output | 16 | Write data, 0 on reads |
| req_rw | output | 1 | 1 = write, 0 = read |

## Verification
Two things can happen in the same cycle: the request pulse from one frame and the acceptance of the first byte of the next frame. The bench provokes this by streaming several frames back to back with no gap. It checks that each pulse still carries the fields of its own frame and that the following frame decodes as a fresh command. Constrained-random frames with mixed terminators, mixed letter case and random strobe gaps are compared against a frame-level model in the bench. The comparison covers the fields and the exact cycle of each pulse relative to its terminator.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_RD = 8'h52;
  localparam logic [7:0] CH_WR = 8'h57;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DROP = 2'd3
  } hcp_state_e;

  typedef struct packed {
    logic       hex;
    logic [3:0] nib;
    logic       term;
    logic       cmd_rd;
    logic       cmd_wr;
  } hcp_class_t;

endpackage

// File: rtl/hcp_classify.sv
module hcp_classify
  import hcp_pkg::*;
#(
  parameter bit LOWER_OK = 1'b1
) (
  input  logic [7:0] byte_i,
  output hcp_class_t cls_o
);

  logic       dec_hit;
  logic [3:0] dec_nib;
  logic       up_hit;
  logic [3:0] up_nib;
  logic       lo_hit;
  logic [3:0] lo_nib;

  always_comb begin
    dec_hit = (byte_i >= 8'h30) && (byte_i <= 8'h39);
    dec_nib = byte_i[3:0];
    up_hit  = (byte_i >= 8'h41) && (byte_i <= 8'h46);
    up_nib  = 4'(byte_i[3:0] + 4'd9);
  end

  generate
    if (LOWER_OK) begin : g_lower
      always_comb begin
        lo_hit = (byte_i >= 8'h61) && (byte_i <= 8'h66);
        lo_nib = 4'(byte_i[3:0] + 4'd9);
      end
    end else begin : g_upper_only
      always_comb begin
        lo_hit = 1'b0;
        lo_nib = 4'd0;
      end
    end
  endgenerate

  always_comb begin
    cls_o.hex    = dec_hit | up_hit | lo_hit;
    cls_o.nib    = dec_hit ? dec_nib : (up_hit ? up_nib : lo_nib);
    cls_o.term   = (byte_i == CH_CR) || (byte_i == CH_LF);
    cls_o.cmd_rd = (byte_i == CH_RD);
    cls_o.cmd_wr = (byte_i == CH_WR);
  end

  always_comb begin
    if (cls_o.hex) begin
      assert_hex_not_term_R7: assert (!cls_o.term && !cls_o.cmd_rd && !cls_o.cmd_wr);
    end
  end

endmodule

// File: rtl/hcp_ctrl.sv
module hcp_ctrl
  import hcp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  hcp_class_t cls,
  output logic       shift_en,
  output logic       clr,
  output logic       fire,
  output logic       fire_wr
);

  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int DATA_NIB = DATA_W / 4;
  localparam int TOT_NIB  = ADDR_NIB + DATA_NIB;
  localparam int CNT_W    = $clog2(TOT_NIB + 2);
  localparam logic [CNT_W-1:0] NEED_RD = CNT_W'(ADDR_NIB);
  localparam logic [CNT_W-1:0] NEED_WR = CNT_W'(TOT_NIB);

  hcp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] need;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shift_en = 1'b0;
    clr      = 1'b0;
    fire     = 1'b0;
    fire_wr  = 1'b0;
    need     = (state_q == ST_WR) ? NEED_WR : NEED_RD;
    if (in_valid) begin
      case (state_q)
        ST_IDLE: begin
          if (cls.term) begin
            state_d = ST_IDLE;
          end else if (cls.cmd_rd) begin
            state_d = ST_RD;
            clr     = 1'b1;
            cnt_d   = '0;
          end else if (cls.cmd_wr) begin
            state_d = ST_WR;
            clr     = 1'b1;
            cnt_d   = '0;
          end else begin
            state_d = ST_DROP;
          end
        end
        ST_RD, ST_WR: begin
          if (cls.term) begin
            fire    = (cnt_q == need);
            fire_wr = (state_q == ST_WR);
            state_d = ST_IDLE;
          end else if (cls.hex && (cnt_q < need)) begin
            shift_en = 1'b1;
            cnt_d    = cnt_q + 1'b1;
          end else begin
            state_d = ST_DROP;
          end
        end
        default: begin
          if (cls.term) state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (in_valid) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_gap_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(state_q) && $stable(cnt_q)));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= NEED_WR);

  assert_drop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DROP && in_valid && !cls.term) |=> state_q == ST_DROP);

  assert_term_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls.term) |=> state_q == ST_IDLE);

endmodule

// File: rtl/hcp_accum.sv
module hcp_accum #(
  parameter int NIBBLES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 shift_en,
  input  logic [3:0]           nib,
  output logic [NIBBLES*4-1:0] value
);

  localparam int W = NIBBLES * 4;

  logic [W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr)           acc_d = '0;
    else if (shift_en) acc_d = {acc_q[W-5:0], nib};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_q <= '0;
    else if (clr || shift_en)  acc_q <= acc_d;
  end

  assign value = acc_q;

  assert_shift_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> acc_q[3:0] == $past(nib));

endmodule

// File: rtl/hex_cmd_parser.sv
module hex_cmd_parser
  import hcp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              req_rw
);

  localparam int NIB = (ADDR_W + DATA_W) / 4;
  localparam int ACC_W = NIB * 4;

  hcp_class_t       cls;
  logic             shift_en, clr, fire, fire_wr;
  logic [ACC_W-1:0] acc;
  logic             term_seen;

  logic              valid_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              rw_d;

  hcp_classify #(.LOWER_OK(1'b1)) u_cls (
    .byte_i (in_data),
    .cls_o  (cls)
  );

  hcp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cls      (cls),
    .shift_en (shift_en),
    .clr      (clr),
    .fire     (fire),
    .fire_wr  (fire_wr)
  );

  hcp_accum #(.NIBBLES(NIB)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .shift_en (shift_en),
    .nib      (cls.nib),
    .value    (acc)
  );

  assign term_seen = in_valid && cls.term;

  always_comb begin
    valid_d = fire;
    addr_d  = req_addr;
    data_d  = req_data;
    rw_d    = req_rw;
    if (fire) begin
      rw_d = fire_wr;
      if (fire_wr) begin
        addr_d = acc[ACC_W-1 -: ADDR_W];
        data_d = acc[DATA_W-1:0];
      end else begin
        addr_d = acc[ADDR_W-1:0];
        data_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
      req_rw    <= 1'b0;
    end else begin
      req_valid <= valid_d;
      if (fire) begin
        req_addr <= addr_d;
        req_data <= data_d;
        req_rw   <= rw_d;
      end
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  assert_pulse_after_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(term_seen));

  assert_read_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_rw) |-> req_data == '0);

  assert_fields_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fire) |-> ($stable(req_addr) && $stable(req_data) && $stable(req_rw)));

endmodule

// File: tb/tb_hex_cmd_parser.sv
module tb_hex_cmd_parser;

  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    logic        rw;
    int          cyc;
  } req_t;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        req_valid;
  logic [15:0] req_addr;
  logic [15:0] req_data;
  logic        req_rw;

  int   n_checks;
  int   n_fail;
  int   cyc;
  bit   done;
  req_t exp_q[$];
  req_t got_q[$];
  byte  unsigned fbuf[$];

  hex_cmd_parser dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_rw    (req_rw)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && req_valid) got_q.push_back('{req_addr, req_data, req_rw, cyc});
  end

  function automatic int hexval(byte unsigned c);
    if (c >= "0" && c <= "9") return int'(c - "0");
    if (c >= "A" && c <= "F") return int'(c - "A") + 10;
    if (c >= "a" && c <= "f") return int'(c - "a") + 10;
    return -1;
  endfunction

  function automatic byte unsigned hexch(int v, bit lower);
    if (v < 10) return byte'(8'h30 + v);
    return lower ? byte'(8'h61 + v - 10) : byte'(8'h41 + v - 10);
  endfunction

  // frame-level model: returns 1 and fields when the buffered frame is good
  function automatic bit eval_frame(output req_t r);
    int need;
    logic [31:0] v;
    r = '{16'h0, 16'h0, 1'b0, 0};
    if (fbuf.size() == 0) return 0;
    if (fbuf[0] == "R") need = 4;
    else if (fbuf[0] == "W") need = 8;
    else return 0;
    if (fbuf.size() != need + 1) return 0;
    v = '0;
    for (int i = 1; i <= need; i++) begin
      if (hexval(fbuf[i]) < 0) return 0;
      v = {v[27:0], 4'(hexval(fbuf[i]))};
    end
    if (need == 8) begin
      r.addr = v[31:16]; r.data = v[15:0]; r.rw = 1'b1;
    end else begin
      r.addr = v[15:0]; r.data = 16'h0; r.rw = 1'b0;
    end
    return 1;
  endfunction

  task automatic send_byte(byte unsigned b);
    req_t r;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_data  = 8'h0A;
    if (b == 8'h0D || b == 8'h0A) begin
      if (eval_frame(r)) begin
        r.cyc = cyc;
        exp_q.push_back(r);
      end
      fbuf.delete();
    end else begin
      fbuf.push_back(b);
    end
  endtask

  task automatic send_str(string s);
    for (int i = 0; i < s.len(); i++) send_byte(byte'(s[i]));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = ($urandom_range(0, 1) == 0) ? 8'h0D : 8'($urandom);
    end
  endtask

  task automatic check_flush(string tag);
    idle(3);
    n_checks++;
    if (got_q.size() != exp_q.size()) begin
      n_fail++;
      $display("FAIL %s: request count actual %0d expected %0d", tag, got_q.size(), exp_q.size());
    end else begin
      for (int i = 0; i < exp_q.size(); i++) begin
        n_checks++;
        if (got_q[i].addr != exp_q[i].addr || got_q[i].data != exp_q[i].data ||
            got_q[i].rw != exp_q[i].rw || got_q[i].cyc != exp_q[i].cyc) begin
          n_fail++;
          $display("FAIL %s/R5: actual addr=%h data=%h rw=%0d cyc=%0d expected addr=%h data=%h rw=%0d cyc=%0d",
                   tag, got_q[i].addr, got_q[i].data, got_q[i].rw, got_q[i].cyc,
                   exp_q[i].addr, exp_q[i].data, exp_q[i].rw, exp_q[i].cyc);
        end
      end
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic send_term(int t);
    if (t == 0) send_byte(8'h0D);
    else if (t == 1) send_byte(8'h0A);
    else begin send_byte(8'h0D); send_byte(8'h0A); end
  endtask

  task automatic random_frame(output string tag);
    int kind, n;
    kind = $urandom_range(0, 5);
    case (kind)
      0: begin tag = "R3"; send_byte("R"); n = 4; end
      1: begin tag = "R8"; send_byte("W"); n = 8; end
      2: begin tag = "R6"; send_byte(($urandom_range(0, 1) == 0) ? "R" : "W");
               n = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 3) : $urandom_range(9, 12); end
      3: begin tag = "R7"; send_byte("R"); n = 4; end
      4: begin tag = "R9"; send_byte("Q"); n = $urandom_range(0, 6); end
      default: begin tag = "R4"; n = 0; end
    endcase
    for (int i = 0; i < n; i++) begin
      if (kind == 3 && i == 2) send_byte(($urandom_range(0, 1) == 0) ? "G" : "#");
      else send_byte(hexch($urandom_range(0, 15), $urandom_range(0, 1) == 1));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    send_term($urandom_range(0, 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    string tag;
    void'($urandom(32'h00C0FFEE));
    n_checks = 0; n_fail = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    n_checks++;
    if (req_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: req_valid in reset actual %b expected 0", req_valid);
    end
    rst_n = 1'b1;
    idle(2);

    send_str("W12345678\r\n");  check_flush("R2");
    send_str("RBABE\n");        check_flush("R3");
    send_str("R0000\r");        check_flush("R4");
    send_str("\r\n\n");         check_flush("R4");
    send_str("WdeadBEEF\n");    check_flush("R8");
    send_str("Rcafe\r\n");      check_flush("R8");
    send_str("RABC\r\n");       check_flush("R6");
    send_str("R12345\n");       check_flush("R6");
    send_str("R\r\n");          check_flush("R6");
    send_str("W1234567\n");     check_flush("R6");
    send_str("W123456789\r");   check_flush("R6");
    send_str("RABCG\r\n");      check_flush("R7");
    send_str("WAB#12345\n");    check_flush("R7");
    send_str("X1234\nR4321\n"); check_flush("R9");
    send_str("R1234\r\nW00FF1234\nR5678\rW9999AAAA\n"); check_flush("R11");

    send_byte("W"); idle(4); send_str("1234"); idle(5); send_str("ABCD"); idle(2); send_byte(8'h0A);
    check_flush("R10");

    // reset in the middle of a frame
    send_str("W12");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    n_checks++;
    if (req_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: req_valid in mid-frame reset actual %b expected 0", req_valid);
    end
    rst_n = 1'b1;
    fbuf.delete();
    send_str("34\n");
    send_str("R00ab\r\n");
    check_flush("R1");

    for (int k = 0; k < 300; k++) begin
      random_frame(tag);
      if ($urandom_range(0, 1) == 0) idle($urandom_range(1, 4));
      if (k % 10 == 9) check_flush(tag);
    end
    check_flush("R11");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule